// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits between a host and a 16-bit parallel NOR flash device. The host hands it one request at a time: read the identifier words, unlock a block, lock a block, erase a block, program one word, or check a range for the erased state. Each request carries a byte address. A program request also carries a data word, and a blank check also carries a length in words. The sequencer turns the request into the device's command write cycles. For erase and program it then polls the device's status word until the device is ready and inspects the error bit that belongs to that operation.

Every operation is framed by read-array commands, so the device is left readable when the operation ends. The flash side uses plain single-cycle strobes. A write strobe carries an address and a data word. A read strobe returns its data on the following cycle. Error history is kept in sticky flags that only the host can clear. A stuck device is caught by a status-poll limit that the host supplies with each request.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, busy, done, err_erase, err_prog, err_tmo and blank_ok are 0, and neither flash strobe is active.
- R2: A request is accepted only while busy is low and req_op is one of 0 (read ID), 1 (unlock), 2 (lock), 3 (erase), 4 (program) or 5 (blank check). Codes 6 and 7 are ignored, and so are requests made while busy. Busy rises in the cycle after acceptance and stays high until done pulses for one cycle, at which point busy is already low. While busy is low no flash strobe is active.
- R3: Every operation starts with a write of 0x00FF to the request address and ends with a write of 0x00FF to that address in the cycle just before done.
- R4: Erase writes 0x0020 and then 0x00D0 to the request address.
- R5: Program writes 0x0040 and then the request data word to the request address.
- R6: After the erase or program writes, the sequencer repeats a write of 0x0070 followed by one read until a read returns bit 7 set. Error bits seen in a status word without bit 7 are ignored.
- R7: When bit 7 is set, erase tests bit 5 and program tests bit 4. If that bit is set, the sequencer writes 0x0050 and sets err_erase or err_prog. The bit that belongs to the other operation is ignored.
- R8: err_erase and err_prog stay set until clr_err is high at a clock edge. Clearing them does not affect anything else.
- R9: Unlock writes 0x0060 then 0x00D0. Lock writes 0x0060 then 0x0001. Neither polls status.
- R10: Read ID writes 0x0090, then reads byte addresses base, base+2 and base+4 into id_mfr, id_dev and id_lock.
- R11: Blank check reads words at addresses start+2i for i = 0 to len-1. It stops at the first word that is not 0xFFFF. blank_ok is 1 at done only if every word read was 0xFFFF. A length of 0 gives blank_ok = 1 with no reads.
- R12: If N consecutive status reads return bit 7 clear, where N is tmo_limit (0 is treated as 1), the operation skips the error test and the 0x0050 write, writes 0x00FF, and ends with err_tmo = 1. err_tmo is cleared when the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Operation code |
| req_addr | input | AW | Byte address (block base, word or range start) |
| req_data | input | 16 | Word to program |
| req_len | input | AW | Blank-check length in words |
| tmo_limit | input | TW | Maximum consecutive not-ready status reads |
| clr_err | input | 1 | Clears the sticky error flags |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err_erase | output | 1 | Sticky erase-failure flag |
| err_prog | output | 1 | Sticky program-failure flag |
| err_tmo | output | 1 | Last operation timed out |
| blank_ok | output | 1 | Last blank check found only erased words |
| id_mfr | output | 16 | Identifier word at offset 0 |
| id_dev | output | 16 | Identifier word at offset 2 |
| id_lock | output | 16 | Block lock word at offset 4 |
| fl_addr | output | AW | Flash byte address |
| fl_wdata | output | 16 | Flash write data |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |
| fl_rdata | input | 16 | Flash read data, valid the cycle after fl_re |

## Verification
The assertions check properties that hold on every cycle. The two strobes are never active together. The flash bus is quiet while the block is idle. done and busy relate as R2 states, each done follows a read-array write, and the error flags stay set until clr_err. The command and data sequences, the choice of status error bit, the identifier capture, the blank-check scan with its early stop, and the timeout count depend on what the device answers. Only the bench's scenarios can show these. The bench runs a device model that logs every bus cycle and compares the logs against sequences it builds from the requirements. It sweeps the ready delay, the injected error bits, the position of the non-erased word and the poll limit.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    localparam int DW = 16;

    typedef enum logic [2:0] {
        OP_READID = 3'd0,
        OP_UNLOCK = 3'd1,
        OP_LOCK   = 3'd2,
        OP_ERASE  = 3'd3,
        OP_PROG   = 3'd4,
        OP_BLANK  = 3'd5
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE, S_RST, S_CMD1, S_CMD2, S_PCMD, S_PRD, S_PCHK,
        S_CLR, S_IDRD, S_IDCAP, S_BRD, S_BCAP, S_FIN
    } st_e;

    localparam logic [DW-1:0] C_ARRAY   = 16'h00FF;
    localparam logic [DW-1:0] C_STATUS  = 16'h0070;
    localparam logic [DW-1:0] C_CLRST   = 16'h0050;
    localparam logic [DW-1:0] C_IDENT   = 16'h0090;
    localparam logic [DW-1:0] C_ERASE   = 16'h0020;
    localparam logic [DW-1:0] C_PROG    = 16'h0040;
    localparam logic [DW-1:0] C_LKSETUP = 16'h0060;
    localparam logic [DW-1:0] C_CONFIRM = 16'h00D0;
    localparam logic [DW-1:0] C_LKSET   = 16'h0001;
    localparam logic [DW-1:0] C_ERASED  = 16'hFFFF;

    localparam int RDY_BIT = 7;
    localparam int ERS_BIT = 5;
    localparam int PRG_BIT = 4;

    typedef struct packed {
        op_e           op;
        logic [DW-1:0] data;
    } req_t;

    function automatic logic op_known(input logic [2:0] code);
        return code <= 3'd5;
    endfunction

    function automatic logic [DW-1:0] first_cmd(input op_e op);
        case (op)
            OP_READID: return C_IDENT;
            OP_ERASE:  return C_ERASE;
            OP_PROG:   return C_PROG;
            default:   return C_LKSETUP;
        endcase
    endfunction

    function automatic logic [DW-1:0] second_cmd(input op_e op, input logic [DW-1:0] data);
        case (op)
            OP_PROG: return data;
            OP_LOCK: return C_LKSET;
            default: return C_CONFIRM;
        endcase
    endfunction

endpackage

// File: rtl/nor_poll_timer.sv
module nor_poll_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          tick,
    input  logic [TW-1:0] limit,
    output logic          expire
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart) cnt_q <= '0;
        else if (tick)      cnt_q <= cnt_q + TW'(1);
    end

    // true when the read now being judged is the limit-th not-ready one
    assign expire = ({1'b0, cnt_q} + (TW+1)'(1)) >= {1'b0, limit};
endmodule

// File: rtl/nor_blank_walk.sv
module nor_blank_walk #(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] start,
    input  logic [AW-1:0] count,
    input  logic          step,
    output logic [AW-1:0] cur_addr,
    output logic          last,
    output logic          empty
);
    logic [AW-1:0] addr_q, left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            left_q <= '0;
        end else if (load) begin
            addr_q <= start;
            left_q <= count;
        end else if (step) begin
            addr_q <= addr_q + AW'(2);
            left_q <= left_q - AW'(1);
        end
    end

    assign cur_addr = addr_q;
    assign last     = (left_q == AW'(1));
    assign empty    = (left_q == '0);
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int AW = 24,
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [2:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    input  logic [AW-1:0] req_len,
    input  logic [TW-1:0] tmo_limit,
    input  logic          clr_err,
    output logic          busy,
    output logic          done,
    output logic          err_erase,
    output logic          err_prog,
    output logic          err_tmo,
    output logic          blank_ok,
    output logic [DW-1:0] id_mfr,
    output logic [DW-1:0] id_dev,
    output logic [DW-1:0] id_lock,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_wdata,
    output logic          fl_we,
    output logic          fl_re,
    input  logic [DW-1:0] fl_rdata
);
    localparam int NID = 3;

    st_e           st_q;
    req_t          req_q;
    logic [AW-1:0] base_q;
    logic [TW-1:0] lim_q;
    logic [1:0]    idk_q;
    logic [DW-1:0] id_q [NID];

    logic          accept, ready, op_err, tick, expire;
    logic          walk_step, walk_last, walk_empty;
    logic [AW-1:0] walk_addr;
    logic          set_ers, set_prg;

    assign accept = (st_q == S_IDLE) && req_valid && op_known(req_op);
    assign ready  = fl_rdata[RDY_BIT];
    assign op_err = (req_q.op == OP_ERASE) ? fl_rdata[ERS_BIT] : fl_rdata[PRG_BIT];
    assign tick   = (st_q == S_PCHK) && !ready;
    assign walk_step = (st_q == S_BCAP) && (fl_rdata == C_ERASED) && !walk_last;
    assign set_ers = (st_q == S_PCHK) && ready && op_err && (req_q.op == OP_ERASE);
    assign set_prg = (st_q == S_PCHK) && ready && op_err && (req_q.op == OP_PROG);

    nor_poll_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst(rst), .restart(st_q == S_CMD2), .tick(tick),
        .limit(lim_q), .expire(expire)
    );

    nor_blank_walk #(.AW(AW)) u_walk (
        .clk(clk), .rst(rst), .load(accept), .start(req_addr), .count(req_len),
        .step(walk_step), .cur_addr(walk_addr), .last(walk_last), .empty(walk_empty)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= S_IDLE;
            req_q     <= '{op: OP_READID, data: '0};
            base_q    <= '0;
            lim_q     <= '0;
            idk_q     <= '0;
            done      <= 1'b0;
            err_erase <= 1'b0;
            err_prog  <= 1'b0;
            err_tmo   <= 1'b0;
            blank_ok  <= 1'b0;
            for (int i = 0; i < NID; i++) id_q[i] <= '0;
        end else begin
            done      <= 1'b0;
            err_erase <= (err_erase && !clr_err) || set_ers;
            err_prog  <= (err_prog  && !clr_err) || set_prg;
            unique case (st_q)
                S_IDLE: if (accept) begin
                    req_q    <= '{op: op_e'(req_op), data: req_data};
                    base_q   <= req_addr;
                    lim_q    <= tmo_limit;
                    err_tmo  <= 1'b0;
                    blank_ok <= 1'b0;
                    st_q     <= S_RST;
                end
                S_RST: begin
                    if (req_q.op != OP_BLANK) st_q <= S_CMD1;
                    else if (walk_empty) begin
                        blank_ok <= 1'b1;
                        st_q     <= S_FIN;
                    end else st_q <= S_BRD;
                end
                S_CMD1: begin
                    idk_q <= '0;
                    st_q  <= (req_q.op == OP_READID) ? S_IDRD : S_CMD2;
                end
                S_CMD2: st_q <= (req_q.op == OP_ERASE || req_q.op == OP_PROG) ? S_PCMD : S_FIN;
                S_PCMD: st_q <= S_PRD;
                S_PRD:  st_q <= S_PCHK;
                S_PCHK: begin
                    if (ready)       st_q <= op_err ? S_CLR : S_FIN;
                    else if (expire) begin
                        err_tmo <= 1'b1;
                        st_q    <= S_FIN;
                    end else         st_q <= S_PCMD;
                end
                S_CLR:  st_q <= S_FIN;
                S_IDRD: st_q <= S_IDCAP;
                S_IDCAP: begin
                    id_q[idk_q] <= fl_rdata;
                    if (idk_q == 2'(NID - 1)) st_q <= S_FIN;
                    else begin
                        idk_q <= idk_q + 2'd1;
                        st_q  <= S_IDRD;
                    end
                end
                S_BRD:  st_q <= S_BCAP;
                S_BCAP: begin
                    if (fl_rdata != C_ERASED) st_q <= S_FIN;
                    else if (walk_last) begin
                        blank_ok <= 1'b1;
                        st_q     <= S_FIN;
                    end else st_q <= S_BRD;
                end
                S_FIN: begin
                    done <= 1'b1;
                    st_q <= S_IDLE;
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        fl_we    = 1'b0;
        fl_re    = 1'b0;
        fl_addr  = base_q;
        fl_wdata = C_ARRAY;
        case (st_q)
            S_RST, S_FIN: fl_we = 1'b1;
            S_CMD1: begin fl_we = 1'b1; fl_wdata = first_cmd(req_q.op); end
            S_CMD2: begin fl_we = 1'b1; fl_wdata = second_cmd(req_q.op, req_q.data); end
            S_PCMD: begin fl_we = 1'b1; fl_wdata = C_STATUS; end
            S_CLR:  begin fl_we = 1'b1; fl_wdata = C_CLRST; end
            S_PRD:  fl_re = 1'b1;
            S_IDRD: begin fl_re = 1'b1; fl_addr = base_q + AW'({idk_q, 1'b0}); end
            S_BRD:  begin fl_re = 1'b1; fl_addr = walk_addr; end
            default: ;
        endcase
    end

    assign busy    = (st_q != S_IDLE);
    assign id_mfr  = id_q[0];
    assign id_dev  = id_q[1];
    assign id_lock = id_q[2];
endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        done,
    input logic        err_erase,
    input logic        err_prog,
    input logic        clr_err,
    input logic        fl_we,
    input logic        fl_re,
    input logic [15:0] fl_wdata
);
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(fl_we && fl_re)); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !fl_we && !fl_re); // R2

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R2

    AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done); // R2

    AST_DONE_AFTER_ARRAY: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(fl_we) && $past(fl_wdata) == 16'h00FF); // R3

    AST_ERS_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_erase && !clr_err |=> err_erase); // R8

    AST_PRG_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_prog && !clr_err |=> err_prog); // R8
endmodule

bind nor_cmd_seq nor_cmd_seq_chk u_chk (
    .clk(clk), .rst(rst), .busy(busy), .done(done),
    .err_erase(err_erase), .err_prog(err_prog), .clr_err(clr_err),
    .fl_we(fl_we), .fl_re(fl_re), .fl_wdata(fl_wdata)
);

// File: tb/nor_cmd_seq_test.sv
`timescale 1ns/1ps
module nor_cmd_seq_test;
    localparam int AW = 8;
    localparam int TW = 8;
    localparam int LD = 2048;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst = 1'b1;
    logic req_valid = 1'b0, clr_err = 1'b0;
    logic [2:0] req_op = '0;
    logic [AW-1:0] req_addr = '0, req_len = '0;
    logic [15:0] req_data = '0;
    logic [TW-1:0] tmo_limit = 8'd10;
    logic busy, done, err_erase, err_prog, err_tmo, blank_ok, fl_we, fl_re;
    logic [15:0] id_mfr, id_dev, id_lock, fl_wdata;
    logic [15:0] fl_rdata = '0;
    logic [AW-1:0] fl_addr;

    nor_cmd_seq #(.AW(AW), .TW(TW)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
        .req_data(req_data), .req_len(req_len), .tmo_limit(tmo_limit), .clr_err(clr_err),
        .busy(busy), .done(done), .err_erase(err_erase), .err_prog(err_prog), .err_tmo(err_tmo),
        .blank_ok(blank_ok), .id_mfr(id_mfr), .id_dev(id_dev), .id_lock(id_lock),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re), .fl_rdata(fl_rdata)
    );

    // device model with bus logging
    logic [15:0] mem [128];
    int mode = 0, pend = 0, bsy = 0, dly = 0, nw = 0, nr = 0, nclr = 0;
    bit hang = 0;
    logic [15:0] errbits = '0, lockst = '0;
    logic [AW-1:0] wa [LD];
    logic [15:0]   wd [LD];
    logic [AW-1:0] ra [LD];

    initial for (int i = 0; i < 128; i++) mem[i] = 16'hFFFF;

    always @(posedge clk) begin
        if (fl_we) begin
            wa[nw % LD] = fl_addr; wd[nw % LD] = fl_wdata; nw++;
            if (pend == 1) begin mem[fl_addr[AW-1:1]] = fl_wdata; bsy = dly; pend = 0; mode = 1; end
            else if (pend == 2) begin if (fl_wdata == 16'h00D0) bsy = dly; pend = 0; mode = 1; end
            else if (pend == 3) begin lockst = (fl_wdata == 16'h0001) ? 16'h0001 : 16'h0000; pend = 0; mode = 1; end
            else case (fl_wdata)
                16'h00FF: mode = 0;
                16'h0070: mode = 1;
                16'h0090: mode = 2;
                16'h0050: nclr++;
                16'h0020: pend = 2;
                16'h0040: pend = 1;
                16'h0060: pend = 3;
                default: ;
            endcase
        end
        if (fl_re) begin
            ra[nr % LD] = fl_addr; nr++;
            if (mode == 1) begin
                if (hang || bsy > 0) begin fl_rdata <= errbits; if (bsy > 0) bsy--; end
                else fl_rdata <= 16'h0080 | errbits;
            end else if (mode == 2) begin
                case (fl_addr[2:0])
                    3'd0: fl_rdata <= 16'h0089;
                    3'd2: fl_rdata <= 16'h0018;
                    3'd4: fl_rdata <= lockst;
                    default: fl_rdata <= 16'h0000;
                endcase
            end else fl_rdata <= mem[fl_addr[AW-1:1]];
        end
    end

    int ntests = 0, nfail = 0;
    logic [AW-1:0] ea [64];
    logic [15:0]   ed [64];
    int en = 0;
    logic [AW-1:0] er [64];
    int ern = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        ntests++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic ew(input logic [AW-1:0] a, input logic [15:0] d);
        ea[en] = a; ed[en] = d; en++;
    endtask

    task automatic cmp_w(input string req, input int base);
        int bad = -1;
        if (nw - base != en) begin check({req, " write count"}, nw - base, en); return; end
        for (int i = 0; i < en; i++)
            if (bad < 0 && (wa[(base + i) % LD] !== ea[i] || wd[(base + i) % LD] !== ed[i])) bad = i;
        if (bad < 0) check(req, 1, 1);
        else check({req, " write seq"}, {8'(bad), wa[(base + bad) % LD], wd[(base + bad) % LD]},
                   {8'(bad), ea[bad], ed[bad]});
    endtask

    task automatic cmp_r(input string req, input int base);
        int bad = -1;
        if (nr - base != ern) begin check({req, " read count"}, nr - base, ern); return; end
        for (int i = 0; i < ern; i++)
            if (bad < 0 && ra[(base + i) % LD] !== er[i]) bad = i;
        if (bad < 0) check(req, 1, 1);
        else check({req, " read addr"}, {8'(bad), ra[(base + bad) % LD]}, {8'(bad), er[bad]});
    endtask

    task automatic do_op(input logic [2:0] op, input logic [AW-1:0] a, input logic [15:0] d,
                         input logic [AW-1:0] len, input bit poke);
        int cyc = 0;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_data = d; req_len = len;
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 busy after accept", busy, 1);
        if (poke) begin
            req_valid = 1'b1; req_op = 3'd1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (!done && cyc < 500) begin @(negedge clk); cyc++; end
        if (!done) check("watchdog", 0, 1);
        else check("R2 busy low at done", busy, 0);
    endtask

    task automatic pulse_clear;
        @(negedge clk); clr_err = 1'b1;
        @(negedge clk); clr_err = 1'b0;
    endtask

    initial begin
        int wb, rb, cb;
        logic [AW-1:0] a;
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check("R1 reset state", {busy, done, err_erase, err_prog, err_tmo, blank_ok, fl_we, fl_re}, 0);

        // R2: unknown codes ignored
        for (int c = 6; c < 8; c++) begin
            wb = nw;
            @(negedge clk); req_valid = 1'b1; req_op = 3'(c);
            @(negedge clk); req_valid = 1'b0;
            check("R2 unknown code ignored", {busy, 8'(nw - wb)}, 0);
        end

        // R4 R6 R7: erase sweep over ready delay and injected bits
        for (int k = 0; k < 4; k++)
            for (int e = 0; e < 4; e++) begin
                a = 8'h80; dly = k; errbits = 16'(e) << 4;
                pulse_clear();
                wb = nw; cb = nclr; en = 0;
                do_op(3'd3, a, 16'h0, 8'h0, k == 2);
                ew(a, 16'h00FF); ew(a, 16'h0020); ew(a, 16'h00D0);
                for (int j = 0; j <= k; j++) ew(a, 16'h0070);
                if (e[1]) ew(a, 16'h0050);
                ew(a, 16'h00FF);
                cmp_w("R3 R4 R6 erase sequence", wb);
                check("R7 erase flag uses bit 5", {err_erase, err_prog, err_tmo}, {e[1], 2'b00});
                check("R7 clear write count", nclr - cb, e[1]);
            end

        // R5 R7: program sweep
        for (int k = 0; k < 4; k++)
            for (int e = 0; e < 4; e++) begin
                a = 8'h60 + 8'(2 * e); d = 16'h1234 ^ (16'(k) * 16'h1111) ^ 16'(e);
                dly = k; errbits = 16'(e) << 4;
                pulse_clear();
                wb = nw; cb = nclr; en = 0;
                do_op(3'd4, a, d, 8'h0, 1'b0);
                ew(a, 16'h00FF); ew(a, 16'h0040); ew(a, d);
                for (int j = 0; j <= k; j++) ew(a, 16'h0070);
                if (e[0]) ew(a, 16'h0050);
                ew(a, 16'h00FF);
                cmp_w("R3 R5 R6 program sequence", wb);
                check("R7 program flag uses bit 4", {err_prog, err_erase}, {e[0], 1'b0});
                check("R5 word stored", mem[a[AW-1:1]], d);
            end

        // R8: stickiness across a clean operation, then clear
        dly = 0; errbits = 16'h0030;
        pulse_clear();
        do_op(3'd3, 8'h80, 16'h0, 8'h0, 1'b0);
        do_op(3'd4, 8'h62, 16'hA5A5, 8'h0, 1'b0);
        check("R8 both flags set", {err_erase, err_prog}, 2'b11);
        errbits = 16'h0000;
        do_op(3'd3, 8'h80, 16'h0, 8'h0, 1'b0);
        check("R8 flags stay set after clean op", {err_erase, err_prog}, 2'b11);
        pulse_clear();
        check("R8 flags cleared", {err_erase, err_prog, busy}, 3'b000);

        // R9 R10: lock / unlock and identifier reads
        for (int l = 0; l < 2; l++) begin
            a = 8'h40;
            wb = nw; en = 0;
            do_op(l ? 3'd2 : 3'd1, a, 16'h0, 8'h0, 1'b0);
            ew(a, 16'h00FF); ew(a, 16'h0060); ew(a, l ? 16'h0001 : 16'h00D0); ew(a, 16'h00FF);
            cmp_w("R3 R9 lock/unlock sequence", wb);
            wb = nw; rb = nr; en = 0; ern = 0;
            do_op(3'd0, a, 16'h0, 8'h0, 1'b0);
            ew(a, 16'h00FF); ew(a, 16'h0090); ew(a, 16'h00FF);
            er[0] = a; er[1] = a + 8'd2; er[2] = a + 8'd4; ern = 3;
            cmp_w("R10 read ID writes", wb);
            cmp_r("R10 read ID addresses", rb);
            check("R10 identifier words", {id_mfr, id_dev, id_lock}, {16'h0089, 16'h0018, 16'(l)});
        end

        // R11: blank check, non-erased word at each position
        for (int b = 0; b < 5; b++) begin
            if (b < 4) mem[8'h10 + b] = 16'hFFFF ^ (16'h1 << b);
            wb = nw; rb = nr; en = 0; ern = 0;
            do_op(3'd5, 8'h20, 16'h0, 8'd4, 1'b0);
            ew(8'h20, 16'h00FF); ew(8'h20, 16'h00FF);
            for (int i = 0; i < 4 && i <= b; i++) begin er[ern] = 8'h20 + 8'(2 * i); ern++; end
            cmp_w("R11 blank writes", wb);
            cmp_r("R11 blank scan", rb);
            check("R11 blank result", blank_ok, b == 4);
            if (b < 4) mem[8'h10 + b] = 16'hFFFF;
        end
        rb = nr;
        do_op(3'd5, 8'h20, 16'h0, 8'd0, 1'b0);
        check("R11 zero length", {blank_ok, 8'(nr - rb)}, {1'b1, 8'd0});

        // R12: timeout with limits 0..3 on a device that never becomes ready
        hang = 1; errbits = 16'h0030; dly = 0;
        for (int L = 0; L < 4; L++) begin
            a = 8'h80; tmo_limit = 8'(L);
            pulse_clear();
            wb = nw; en = 0;
            do_op(3'd3, a, 16'h0, 8'h0, 1'b0);
            ew(a, 16'h00FF); ew(a, 16'h0020); ew(a, 16'h00D0);
            for (int j = 0; j < (L == 0 ? 1 : L); j++) ew(a, 16'h0070);
            ew(a, 16'h00FF);
            cmp_w("R12 timeout sequence", wb);
            check("R12 timeout flags", {err_tmo, err_erase}, 2'b10);
        end
        hang = 0; errbits = 16'h0000; tmo_limit = 8'd10;
        do_op(3'd4, 8'h70, 16'h0F0F, 8'h0, 1'b0);
        check("R12 timeout flag cleared by next request", err_tmo, 0);

        $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end
endmodule